// File: doc/BRIEF.md
# PC Card Byte-Lane Steering Decoder

This block sits between the host side of a 16-bit PC Card data bus and a 16-bit internal register port. It watches the host card enables, the address bus, the attribute-space select and the two pairs of strobes. Memory cycles use output enable and write enable. I/O cycles use I/O read and I/O write. From these it decides which external byte lanes the card drives on a read, and which internal byte the low lane carries. On writes it produces a one-cycle byte-enable pulse toward the internal registers, with each host byte moved to the correct half of the internal word. It also drives the I/O input acknowledge and the 16-bit port indication. A static mode input switches it to the IDE-style decode. In that mode the two card enables act as the task-file select and the control-block select.

All host controls, the address and the write data are asynchronous to the system clock. They pass through a two-flop synchronizer. Every output is registered. Read-side outputs therefore follow the host inputs three clock cycles later. A write is committed when the synchronized write strobe returns high, using the address and data held while the strobe was low. Internal register contents and nanosecond bus timing lie outside this block.

Top module: `pcl_lane_steer`

## Requirements
- R1: With both card enables high the card is deselected: neither lane enable is asserted, no write pulse occurs, `inpack_n` and `iois16_n` stay high, and `port_space` is 00. This is also the state after reset.
- R2: With `ce1_n`=0 and `ce2_n`=1 in a common-memory or accepted I/O cycle, only the low lane is used. A0=0 selects internal byte 0 (bits 7:0). A0=1 selects internal byte 1 (bits 15:8) and sets `lane_lo_odd`. A write uses `port_wr_be`=01 or 10 respectively, with the host low byte placed in the selected internal byte.
- R3: With both card enables low in a common-memory or accepted I/O cycle, both lanes are used and A0 has no effect. The low lane carries internal byte 0 and the high lane internal byte 1. A write uses `port_wr_be`=11.
- R4: With `ce1_n`=1 and `ce2_n`=0, only the high lane carries internal byte 1 and the low lane enable stays off. A write uses `port_wr_be`=10 with host bits 15:8.
- R5: In an attribute cycle (`reg_n`=0 with `oe_n` or `we_n` low) only the low lane carries internal byte 0, and the high lane is never enabled. The access is valid when `ce1_n`=0 and either `ce2_n`=0 or A0=0. Any other attribute access (odd byte) drives nothing and writes nothing.
- R6: An attribute write is accepted only when address bit 9 is 1, the configuration region. A write with address bit 9 at 0 (information-structure area) produces no write pulse.
- R7: An I/O strobe while `reg_n` is high is inhibited. No lane, no write, and `inpack_n`/`iois16_n` stay high.
- R8: `inpack_n` is low only during an I/O read with `reg_n` low, the card selected, and the address inside the 16-byte I/O window at `IO_BASE` (address bits 10:4 equal 0x1F by default). It stays high in IDE mode.
- R9: In card mode `iois16_n` is low whenever the card is selected, `reg_n` is low, the address is inside the I/O window and neither memory strobe is low.
- R10: In IDE mode with only `ce1_n` low (task-file select), address bits 2:0 choose the register and the upper address lines must be zero. Index 0 is the data register: both lanes, `port_wr_be`=11, `iois16_n` low. Other indices use the low lane only with `port_wr_be`=01. `port_space` is 01.
- R11: In IDE mode with only `ce2_n` low, index 6 selects the control register on the low lane with `port_space`=11. Any other index, or both selects low, drives nothing, writes nothing and leaves `iois16_n` high.
- R12: A write is committed as one `port_wr_be` pulse of exactly one cycle after the synchronized write strobe (`we_n` or `iowr_n`) rises. During that pulse, `port_addr`, `port_wdata` and `port_space` carry the address, steered data and space held while the strobe was low. Space codes: 00 none, 01 common memory/I/O/task file, 10 attribute, 11 IDE control.
- R13: Read-side outputs reflect a host input change after exactly three rising clock edges: two synchronizer flops and the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ide_mode | input | 1 | Static mode select: 1 selects IDE-style decode |
| ce1_n | input | 1 | Card enable 1 (task-file select in IDE mode), active low |
| ce2_n | input | 1 | Card enable 2 (control-block select in IDE mode), active low |
| reg_n | input | 1 | Attribute/I/O space select, active low |
| oe_n | input | 1 | Memory read strobe, active low |
| we_n | input | 1 | Memory write strobe, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| host_addr | input | ADDR_W | Host address bus |
| host_din | input | 16 | Host write data |
| host_dout | output | 16 | Steered read data, zero on undriven lanes |
| lane_lo_oe | output | 1 | Drive enable for host bits 7:0 |
| lane_hi_oe | output | 1 | Drive enable for host bits 15:8 |
| lane_lo_odd | output | 1 | Low lane carries internal byte 1 |
| inpack_n | output | 1 | I/O read acknowledge, active low |
| iois16_n | output | 1 | Addressed port accepts 16-bit access, active low |
| port_space | output | 2 | Space of the current or committed access |
| port_addr | output | ADDR_W | Address toward the internal port |
| port_wr_be | output | 2 | One-cycle write byte enables |
| port_wdata | output | 16 | Steered write data |
| port_rdata | input | 16 | Internal register read data |

## Verification
The assertions check several properties on every cycle. Deselection and a dual select in IDE mode silence all lanes. The high lane stays off in attribute cycles. I/O strobes with the space select high are inhibited. The acknowledge only follows a real I/O read. A write pulse never lasts longer than one cycle. Only the bench scenarios can show the lane assignment and byte placement for each enable and A0 combination, the window and bit-9 address filters, the exact data and address carried by each committed write, and the three-cycle read latency. These are covered by a near-exhaustive sweep of enables, strobes, A0 and address classes in both modes.

// File: rtl/pcl_pkg.sv
`timescale 1ns/1ps
package pcl_pkg;

    typedef enum logic [1:0] {
        SP_NONE = 2'b00,
        SP_DATA = 2'b01,
        SP_ATTR = 2'b10,
        SP_CTRL = 2'b11
    } space_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2_n;
        logic reg_n;
        logic oe_n;
        logic we_n;
        logic iord_n;
        logic iowr_n;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);
    localparam strobe_t STROBE_IDLE = '1;

    typedef struct packed {
        logic   rd;
        logic   wr;
        logic   lo;
        logic   hi;
        logic   lo_odd;
        space_e space;
        logic   inpack;
        logic   iois16;
    } dec_t;

endpackage

// File: rtl/pcl_sync.sv
`timescale 1ns/1ps
module pcl_sync #(
    parameter int          W        = 8,
    parameter int          STAGES   = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pcl_decode.sv
`timescale 1ns/1ps
module pcl_decode
    import pcl_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int IO_BASE     = 'h1F0,
    parameter int IO_WIN_LOG2 = 4,
    parameter int CFG_BIT     = 9,
    parameter int IDE_ALT_IDX = 6
) (
    input  logic              ide_mode,
    input  strobe_t           st,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    localparam logic [ADDR_W-1:0] IO_BASE_V = ADDR_W'(IO_BASE);
    localparam logic [2:0]        ALT_V     = 3'(IDE_ALT_IDX);

    logic sel, io_hit, ide_hi_zero;
    logic no_io_strb, no_mem_strb;
    logic mem_rd, mem_wr, io_rd, io_wr;

    always_comb begin
        dec         = '0;
        sel         = !st.ce1_n || !st.ce2_n;
        io_hit      = addr[ADDR_W-1:IO_WIN_LOG2] == IO_BASE_V[ADDR_W-1:IO_WIN_LOG2];
        ide_hi_zero = addr[ADDR_W-1:3] == '0;
        no_io_strb  = st.iord_n && st.iowr_n;
        no_mem_strb = st.oe_n && st.we_n;
        mem_rd      = !st.oe_n && st.we_n && no_io_strb;
        mem_wr      = !st.we_n && st.oe_n && no_io_strb;
        io_rd       = !st.iord_n && st.iowr_n && no_mem_strb && !st.reg_n && io_hit;
        io_wr       = !st.iowr_n && st.iord_n && no_mem_strb && !st.reg_n && io_hit;

        if (ide_mode) begin
            if (!st.ce1_n && st.ce2_n && ide_hi_zero) begin
                dec.lo     = 1'b1;
                dec.hi     = addr[2:0] == 3'd0;
                dec.iois16 = addr[2:0] == 3'd0;
                dec.space  = SP_DATA;
                dec.rd     = !st.iord_n && st.iowr_n;
                dec.wr     = !st.iowr_n && st.iord_n;
            end else if (st.ce1_n && !st.ce2_n && ide_hi_zero && addr[2:0] == ALT_V) begin
                dec.lo     = 1'b1;
                dec.space  = SP_CTRL;
                dec.rd     = !st.iord_n && st.iowr_n;
                dec.wr     = !st.iowr_n && st.iord_n;
            end
        end else if (sel) begin
            if (!st.reg_n && (mem_rd || mem_wr)) begin
                // attribute space: even byte only, low lane only
                if (!st.ce1_n && (!st.ce2_n || !addr[0])) begin
                    dec.lo    = 1'b1;
                    dec.space = SP_ATTR;
                    dec.rd    = mem_rd;
                    dec.wr    = mem_wr && addr[CFG_BIT];
                end
            end else if ((st.reg_n && (mem_rd || mem_wr)) || io_rd || io_wr) begin
                dec.space = SP_DATA;
                dec.rd    = mem_rd || io_rd;
                dec.wr    = mem_wr || io_wr;
                unique case ({st.ce2_n, st.ce1_n})
                    2'b10: begin
                        dec.lo     = 1'b1;
                        dec.lo_odd = addr[0];
                    end
                    2'b00: begin
                        dec.lo = 1'b1;
                        dec.hi = 1'b1;
                    end
                    2'b01:   dec.hi = 1'b1;
                    default: dec.hi = 1'b0;
                endcase
            end
            dec.inpack = io_rd;
            dec.iois16 = !st.reg_n && io_hit && no_mem_strb;
        end

        if (!(dec.rd || dec.wr)) dec.space = SP_NONE;
    end

endmodule

// File: rtl/pcl_lane_steer.sv
`timescale 1ns/1ps
module pcl_lane_steer
    import pcl_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2,
    parameter int IO_BASE     = 'h1F0,
    parameter int IO_WIN_LOG2 = 4,
    parameter int CFG_BIT     = 9,
    parameter int IDE_ALT_IDX = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ide_mode,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              reg_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              iord_n,
    input  logic              iowr_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_din,
    output logic [15:0]       host_dout,
    output logic              lane_lo_oe,
    output logic              lane_hi_oe,
    output logic              lane_lo_odd,
    output logic              inpack_n,
    output logic              iois16_n,
    output logic [1:0]        port_space,
    output logic [ADDR_W-1:0] port_addr,
    output logic [1:0]        port_wr_be,
    output logic [15:0]       port_wdata,
    input  logic [15:0]       port_rdata
);

    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = BYTE_W * LANES;
    localparam int SYNC_W = STROBE_W + ADDR_W + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {STROBE_IDLE, {(ADDR_W + DATA_W){1'b0}}};
    localparam int TAPS   = 2;   // tap 0: current sample, tap 1: previous sample

    typedef struct packed {
        strobe_t             prev_st;
        logic [ADDR_W-1:0]   prev_addr;
        logic [DATA_W-1:0]   prev_din;
        logic                lo_oe;
        logic                hi_oe;
        logic                lo_odd;
        logic [DATA_W-1:0]   dout;
        logic                inpack_n;
        logic                iois16_n;
        space_e              space;
        logic [ADDR_W-1:0]   addr;
        logic [LANES-1:0]    be;
        logic [DATA_W-1:0]   wdata;
    } state_t;

    localparam state_t STATE_RST = '{
        prev_st:  STROBE_IDLE,
        prev_addr: '0,
        prev_din: '0,
        lo_oe:    1'b0,
        hi_oe:    1'b0,
        lo_odd:   1'b0,
        dout:     '0,
        inpack_n: 1'b1,
        iois16_n: 1'b1,
        space:    SP_NONE,
        addr:     '0,
        be:       '0,
        wdata:    '0
    };

    logic [SYNC_W-1:0] sync_q;
    strobe_t           cur_st;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_din;
    strobe_t           tap_st   [TAPS];
    logic [ADDR_W-1:0] tap_addr [TAPS];
    dec_t              tap_dec  [TAPS];
    state_t            state_d, state_q;
    logic              commit;

    pcl_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce1_n, ce2_n, reg_n, oe_n, we_n, iord_n, iowr_n, host_addr, host_din}),
        .q     (sync_q)
    );

    assign {cur_st, cur_addr, cur_din} = sync_q;
    assign tap_st[0]   = cur_st;
    assign tap_addr[0] = cur_addr;
    assign tap_st[1]   = state_q.prev_st;
    assign tap_addr[1] = state_q.prev_addr;

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        pcl_decode #(
            .ADDR_W      (ADDR_W),
            .IO_BASE     (IO_BASE),
            .IO_WIN_LOG2 (IO_WIN_LOG2),
            .CFG_BIT     (CFG_BIT),
            .IDE_ALT_IDX (IDE_ALT_IDX)
        ) u_dec (
            .ide_mode (ide_mode),
            .st       (tap_st[t]),
            .addr     (tap_addr[t]),
            .dec      (tap_dec[t])
        );
    end

    always_comb begin
        state_d           = state_q;
        state_d.prev_st   = cur_st;
        state_d.prev_addr = cur_addr;
        state_d.prev_din  = cur_din;

        // trailing edge: previous sample was a write, both write strobes now high
        commit = tap_dec[1].wr && cur_st.we_n && cur_st.iowr_n;

        state_d.lo_oe    = tap_dec[0].rd && tap_dec[0].lo;
        state_d.hi_oe    = tap_dec[0].rd && tap_dec[0].hi;
        state_d.lo_odd   = tap_dec[0].lo_odd && (tap_dec[0].rd || tap_dec[0].wr);
        state_d.inpack_n = !tap_dec[0].inpack;
        state_d.iois16_n = !tap_dec[0].iois16;

        state_d.dout = '0;
        if (state_d.lo_oe)
            state_d.dout[BYTE_W-1:0] = tap_dec[0].lo_odd ? port_rdata[DATA_W-1:BYTE_W]
                                                         : port_rdata[BYTE_W-1:0];
        if (state_d.hi_oe)
            state_d.dout[DATA_W-1:BYTE_W] = port_rdata[DATA_W-1:BYTE_W];

        if (commit) begin
            state_d.space = tap_dec[1].space;
            state_d.addr  = state_q.prev_addr;
            state_d.be    = {tap_dec[1].hi || (tap_dec[1].lo && tap_dec[1].lo_odd),
                             tap_dec[1].lo && !tap_dec[1].lo_odd};
            state_d.wdata = {tap_dec[1].lo_odd ? state_q.prev_din[BYTE_W-1:0]
                                               : state_q.prev_din[DATA_W-1:BYTE_W],
                             state_q.prev_din[BYTE_W-1:0]};
        end else begin
            state_d.space = tap_dec[0].space;
            state_d.addr  = cur_addr;
            state_d.be    = '0;
            state_d.wdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STATE_RST;
        else        state_q <= state_d;
    end

    assign host_dout   = state_q.dout;
    assign lane_lo_oe  = state_q.lo_oe;
    assign lane_hi_oe  = state_q.hi_oe;
    assign lane_lo_odd = state_q.lo_odd;
    assign inpack_n    = state_q.inpack_n;
    assign iois16_n    = state_q.iois16_n;
    assign port_space  = state_q.space;
    assign port_addr   = state_q.addr;
    assign port_wr_be  = state_q.be;
    assign port_wdata  = state_q.wdata;

endmodule

// File: rtl/pcl_lane_steer_chk.sv
`timescale 1ns/1ps
module pcl_lane_steer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ide_mode,
    input logic       ce1_n,
    input logic       ce2_n,
    input logic       reg_n,
    input logic       oe_n,
    input logic       we_n,
    input logic       iord_n,
    input logic       iowr_n,
    input logic       lane_lo_oe,
    input logic       lane_hi_oe,
    input logic       inpack_n,
    input logic       iois16_n,
    input logic [1:0] port_wr_be
);

    // edges seen since reset, saturating; three are needed before $past(...,3) is meaningful
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    a_r1_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(ce1_n && ce2_n, 3))
        |-> (!lane_lo_oe && !lane_hi_oe && inpack_n && iois16_n));

    a_r5_attr_no_high_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(!ide_mode && !reg_n && (!oe_n || !we_n), 3))
        |-> !lane_hi_oe);

    a_r7_reg_high_inhibits_io: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(!ide_mode && reg_n && oe_n && we_n, 3))
        |-> (!lane_lo_oe && !lane_hi_oe && inpack_n && iois16_n));

    a_r8_inpack_needs_io_read: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && !inpack_n)
        |-> $past(!ide_mode && !iord_n && !reg_n && !(ce1_n && ce2_n), 3));

    a_r11_dual_select_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(ide_mode && !ce1_n && !ce2_n, 3))
        |-> (!lane_lo_oe && !lane_hi_oe && iois16_n));

    a_r12_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr_be != 2'b00) |=> (port_wr_be == 2'b00));

endmodule

bind pcl_lane_steer pcl_lane_steer_chk u_chk (.*);

// File: tb/sim_pcl_lane_steer.sv
`timescale 1ns/1ps
module sim_pcl_lane_steer;

    localparam int          AW = 11;
    localparam logic [15:0] RD = 16'hB7A4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ide_mode = 1'b0;
    logic          ce1_n = 1'b1, ce2_n = 1'b1, reg_n = 1'b1;
    logic          oe_n = 1'b1, we_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
    logic [AW-1:0] host_addr = '0;
    logic [15:0]   host_din = '0;
    logic [15:0]   host_dout;
    logic          lane_lo_oe, lane_hi_oe, lane_lo_odd, inpack_n, iois16_n;
    logic [1:0]    port_space, port_wr_be;
    logic [AW-1:0] port_addr;
    logic [15:0]   port_wdata;
    logic [15:0]   port_rdata = RD;

    pcl_lane_steer #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ide_mode(ide_mode),
        .ce1_n(ce1_n), .ce2_n(ce2_n), .reg_n(reg_n),
        .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n),
        .host_addr(host_addr), .host_din(host_din), .host_dout(host_dout),
        .lane_lo_oe(lane_lo_oe), .lane_hi_oe(lane_hi_oe), .lane_lo_odd(lane_lo_odd),
        .inpack_n(inpack_n), .iois16_n(iois16_n),
        .port_space(port_space), .port_addr(port_addr),
        .port_wr_be(port_wr_be), .port_wdata(port_wdata), .port_rdata(port_rdata)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic [1:0]    cap_be;
    logic [15:0]   cap_wd;
    logic [AW-1:0] cap_addr;
    logic [1:0]    cap_sp;

    always @(negedge clk) begin
        if (rst_n && port_wr_be != 2'b00) begin
            pulses   = pulses + 1;
            cap_be   = port_wr_be;
            cap_wd   = port_wdata;
            cap_addr = port_addr;
            cap_sp   = port_space;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // kind: 0 memory read, 1 memory write, 2 I/O read, 3 I/O write
    task automatic run(input bit ide, input bit c1, input bit c2, input bit rg,
                       input int kind, input logic [AW-1:0] a, input logic [15:0] d);
        bit    sel  = !(c1 && c2);
        bit    rdk  = (kind == 0 || kind == 2);
        bit    memk = (kind < 2);
        bit    hit  = (a[AW-1:4] == 7'h1F);
        bit    acc = 0, lo = 0, hi = 0, odd = 0, inp = 0, i16i = 0, i16s = 0;
        logic [1:0] sp = 2'b00, be = 2'b00;
        string tg, tg16;
        if (ide) begin
            tg16 = "R10";
            if (!sel) tg = "R1";
            else if (!c1 && c2 && a[AW-1:3] == 0) begin
                acc = 1; lo = 1; hi = (a[2:0] == 0); sp = 2'b01;
                i16i = hi; i16s = hi; tg = "R10";
            end else if (c1 && !c2 && a[AW-1:3] == 0 && a[2:0] == 3'd6) begin
                acc = 1; lo = 1; sp = 2'b11; tg = "R11";
            end else tg = "R11";
        end else begin
            tg16 = "R9";
            if (!sel) tg = "R1";
            else if (memk && !rg) begin
                tg = "R5";
                if (!c1 && (!c2 || !a[0])) begin
                    if (rdk || a[9]) begin acc = 1; lo = 1; sp = 2'b10; end
                    else tg = "R6";
                end
            end else if (!memk && rg) tg = "R7";
            else if (memk || hit) begin
                acc = 1; sp = 2'b01;
                case ({c2, c1})
                    2'b10: begin lo = 1; odd = a[0]; tg = "R2"; end
                    2'b00: begin lo = 1; hi = 1; tg = "R3"; end
                    default: begin hi = 1; tg = "R4"; end
                endcase
            end else tg = "R8";
            inp  = sel && !memk && rdk && !rg && hit;
            i16i = sel && !rg && hit;
            i16s = i16i && !memk;
        end
        if (acc && !rdk) be = {hi || (lo && odd), lo && !odd};

        @(negedge clk);
        ide_mode = ide; ce1_n = c1; ce2_n = c2; reg_n = rg;
        host_addr = a; host_din = d;
        oe_n = 1; we_n = 1; iord_n = 1; iowr_n = 1;
        repeat (4) @(negedge clk);
        chk(tg16, "iois16_n idle", iois16_n, !i16i);
        chk(tg, "lo_oe idle", lane_lo_oe, 0);

        pulses = 0;
        case (kind)
            0: oe_n = 0;
            1: we_n = 0;
            2: iord_n = 0;
            default: iowr_n = 0;
        endcase
        repeat (4) @(negedge clk);
        chk(tg, "lane_lo_oe", lane_lo_oe, rdk && lo);
        chk(tg, "lane_hi_oe", lane_hi_oe, rdk && hi);
        chk("R8", "inpack_n", inpack_n, !inp);
        chk(tg16, "iois16_n strobe", iois16_n, !i16s);
        chk(tg, "port_space", port_space, acc ? sp : 2'b00);
        if (rdk && lo) begin
            chk(tg, "lane_lo_odd", lane_lo_odd, odd);
            chk(tg, "dout low", host_dout[7:0], odd ? RD[15:8] : RD[7:0]);
        end
        if (rdk && hi) chk(tg, "dout high", host_dout[15:8], RD[15:8]);

        oe_n = 1; we_n = 1; iord_n = 1; iowr_n = 1;
        repeat (5) @(negedge clk);
        chk((be != 0) ? "R12" : tg, "write pulses", pulses, (be != 0) ? 1 : 0);
        if (be != 0 && pulses == 1) begin
            chk(tg, "write be", cap_be, be);
            if (be[0]) chk("R12", "wdata low", cap_wd[7:0], d[7:0]);
            if (be[1]) chk("R12", "wdata high", cap_wd[15:8], odd ? d[7:0] : d[15:8]);
            chk("R12", "commit addr", cap_addr, a);
            chk("R12", "commit space", cap_sp, sp);
        end
        ce1_n = 1; ce2_n = 1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "reset lo_oe", lane_lo_oe, 0);
        chk("R1", "reset hi_oe", lane_hi_oe, 0);
        chk("R1", "reset inpack_n", inpack_n, 1);
        chk("R1", "reset iois16_n", iois16_n, 1);
        chk("R1", "reset be", port_wr_be, 0);
        chk("R1", "reset space", port_space, 0);

        // R13: word read appears after exactly three rising edges
        ce1_n = 0; ce2_n = 0; reg_n = 1; host_addr = '0; oe_n = 0;
        repeat (2) @(negedge clk);
        chk("R13", "lo_oe after two edges", lane_lo_oe, 0);
        @(negedge clk);
        chk("R13", "lo_oe after three edges", lane_lo_oe, 1);
        chk("R13", "hi_oe after three edges", lane_hi_oe, 1);
        oe_n = 1; ce1_n = 1; ce2_n = 1;
        repeat (4) @(negedge clk);

        for (int rg = 0; rg < 2; rg++)
            for (int kind = 0; kind < 4; kind++)
                for (int cv = 0; cv < 4; cv++)
                    for (int a0 = 0; a0 < 2; a0++)
                        for (int asel = 0; asel < 2; asel++) begin
                            logic [AW-1:0] a;
                            logic [7:0]    k;
                            a = asel[0] ? (11'h200 | 11'(a0)) : (11'h1F2 | 11'(a0));
                            k = 8'(cv * 16 + kind * 4 + a0 * 2 + asel + rg * 64);
                            run(1'b0, cv[0], cv[1], rg[0], kind, a, {8'h5A ^ k, 8'hC3 ^ k});
                        end

        for (int kind = 2; kind < 4; kind++)
            for (int cv = 0; cv < 4; cv++)
                for (int ix = 0; ix < 8; ix++) begin
                    logic [7:0] k;
                    k = 8'(ix + cv * 8 + kind * 32);
                    run(1'b1, cv[0], cv[1], 1'b1, kind, 11'(ix), {8'h96 ^ k, 8'h3D ^ k});
                end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule